// File: doc/BRIEF.md
# NAND Unique-Identifier Fetch and Check Sequencer

This block reads the factory-programmed unique identifier from a raw NAND flash die over an asynchronous 8-bit bus and checks it before handing it on. A single start pulse launches the operation. First the block tests the capability bit in the die's optional-command field, and it refuses the request when that bit is clear. Otherwise it latches the unique-ID opcode with the command latch strobe and one zero address byte with the address latch strobe. It then lets the programmed busy-assert delay pass and waits for the ready/busy line to return high, bounded by a programmable limit. A programmable ready-to-read gap follows, and then the block clocks data out with read-enable pulses.

The die returns the identifier as a series of redundant copies. Each copy holds the identifier bytes followed by the same number of check bytes, and the check bytes are meant to be the bitwise complement of the identifier bytes. The block checks each copy as it arrives and stops at the first copy that passes. It then publishes the manufacturer byte together with the validated identifier bytes on a wide output register and reports done. If the die never returns ready, or if no copy passes, the block reports done with an error code.

Top module: `nand_uid_reader`

## Requirements
- R1: After reset, busy, done and error are 0, errCode is 0, idOut is all zeros, WE# and RE# are high, and neither latch strobe is asserted.
- R2: A start while idle with bit 5 of optCmd clear completes on the next clock with done=1, error=1 and errCode=1. No WE# or RE# pulse is produced.
- R3: An accepted start produces exactly one command byte 0xED, latched on the rising edge of WE# with the command strobe high. One address byte 0x00 follows, latched on the rising edge of WE# with the address strobe high. The two strobes are never high together, WE# and RE# are never low together, and dqOe is high whenever WE# is low.
- R4: After the address byte the ready/busy line is ignored for tWbCycles cycles. The first RE# falling edge comes at least tRrCycles cycles after the ready/busy line returns high.
- R5: If the ready/busy line stays low for tRCycles cycles of the ready wait, the block finishes with done=1, error=1 and errCode=2, and it issues no RE# pulse.
- R6: A data byte is captured on each rising edge of RE#. Each copy is 32 bytes. A copy passes only if, for every j from 0 to 15, byte j XOR byte j+16 equals 0xFF. A single flipped bit in any byte pair fails the copy.
- R7: When copy k (counting from 0) is the first passing copy, exactly 32*(k+1) RE# pulses are issued, and the result is done=1, error=0, errCode=0.
- R8: If none of 16 copies passes, the block finishes after 512 RE# pulses with done=1, error=1 and errCode=3.
- R9: On success idOut[135:128] holds mfrId and idOut[127-8j -: 8] holds identifier byte j of the passing copy. idOut changes at no other time.
- R10: busy is high from the clock after an accepted start until completion, and it is never high together with done. done, error and errCode hold until the next accepted start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| optCmd | input | 16 | Optional-command capability field of the die |
| mfrId | input | 8 | Manufacturer byte placed on top of the result |
| tWbCycles | input | TMR_W | Busy-assert delay, in cycles |
| tRCycles | input | TMR_W | Ready-wait limit, in cycles |
| tRrCycles | input | TMR_W | Ready-to-first-read gap, in cycles |
| nandRbN | input | 1 | Ready/busy line from the die, low while busy |
| dqIn | input | 8 | Data bus from the die |
| nandCmdLatch | output | 1 | Command latch strobe |
| nandAddrLatch | output | 1 | Address latch strobe |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| dqOut | output | 8 | Data bus driven toward the die |
| dqOe | output | 1 | Output enable for dqOut |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (held) |
| error | output | 1 | Operation finished with an error (held) |
| errCode | output | 2 | 0 none, 1 unsupported, 2 ready timeout, 3 no valid copy |
| idOut | output | 136 | Manufacturer byte and validated identifier |

## Verification
The bench uses the default parameters: 16 identifier bytes and 16 copies. This brings the full 512-byte read with no passing copy, and a pass on the very last copy, within reach. The timing inputs are small (tWbCycles=4, tRCycles=60, tRrCycles=3), so the ready timeout and the spacing rules show up within a few dozen cycles. Bad copies carry a single flipped bit at a different byte position each time, so every byte pair comparison gets exercised.

// File: rtl/nand_uid_pkg.sv
package nand_uid_pkg;
  localparam logic [7:0] UID_OPCODE  = 8'hED;
  localparam logic [7:0] UID_ADDRESS = 8'h00;
  localparam int         CAP_BIT     = 5;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_UNSUP   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_NOCOPY  = 2'd3
  } uidErr_t;

  typedef struct packed {
    logic clrTimer;
    logic incTimer;
    logic clrByte;
    logic capByte;
    logic clrCopy;
    logic incCopy;
    logic latchId;
  } uidStrobe_t;

  typedef struct packed {
    logic rbReady;
    logic wbHit;
    logic rHit;
    logic rrHit;
    logic copyFull;
    logic lastCopy;
    logic copyOk;
  } uidStatus_t;
endpackage

// File: rtl/uid_datapath.sv
module uid_datapath
  import nand_uid_pkg::*;
#(
  parameter int ID_BYTES   = 16,
  parameter int MAX_COPIES = 16,
  parameter int TMR_W      = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  uidStrobe_t                stb,
  input  logic [TMR_W-1:0]          tWbCycles,
  input  logic [TMR_W-1:0]          tRCycles,
  input  logic [TMR_W-1:0]          tRrCycles,
  input  logic                      nandRbN,
  input  logic [7:0]                dqIn,
  input  logic [7:0]                mfrId,
  output uidStatus_t                sts,
  output logic [(ID_BYTES+1)*8-1:0] idOut
);
  localparam int COPY_BYTES = 2 * ID_BYTES;
  localparam int BCW        = $clog2(COPY_BYTES + 1);
  localparam int BIW        = $clog2(COPY_BYTES);
  localparam int CCW        = (MAX_COPIES > 1) ? $clog2(MAX_COPIES) : 1;

  logic [1:0]       rbSync;
  logic [TMR_W-1:0] timer;
  logic [TMR_W:0]   timerNext;
  logic [BCW-1:0]   byteCnt;
  logic [CCW-1:0]   copyCnt;
  logic [7:0]       copyBuf [COPY_BYTES];
  logic [ID_BYTES-1:0] pairOk;

  always_ff @(posedge clk) begin
    if (!rstN) rbSync <= 2'b11;
    else       rbSync <= {rbSync[0], nandRbN};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             timer <= '0;
    else if (stb.clrTimer) timer <= '0;
    else if (stb.incTimer) timer <= timer + 1'b1;
  end

  assign timerNext = {1'b0, timer} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)            byteCnt <= '0;
    else if (stb.clrByte) byteCnt <= '0;
    else if (stb.capByte) byteCnt <= byteCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.capByte) copyBuf[byteCnt[BIW-1:0]] <= dqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            copyCnt <= '0;
    else if (stb.clrCopy) copyCnt <= '0;
    else if (stb.incCopy) copyCnt <= copyCnt + 1'b1;
  end

  for (genvar j = 0; j < ID_BYTES; j++) begin : g_pair
    assign pairOk[j] = ((copyBuf[j] ^ copyBuf[j + ID_BYTES]) == 8'hFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) idOut <= '0;
    else if (stb.latchId) begin
      idOut[(ID_BYTES+1)*8-1 -: 8] <= mfrId;
      for (int j = 0; j < ID_BYTES; j++)
        idOut[(ID_BYTES-1-j)*8 +: 8] <= copyBuf[j];
    end
  end

  assign sts.rbReady  = rbSync[1];
  assign sts.wbHit    = (timerNext >= {1'b0, tWbCycles});
  assign sts.rHit     = (timerNext >= {1'b0, tRCycles});
  assign sts.rrHit    = (timerNext >= {1'b0, tRrCycles});
  assign sts.copyFull = (byteCnt == BCW'(COPY_BYTES));
  assign sts.lastCopy = (copyCnt == CCW'(MAX_COPIES - 1));
  assign sts.copyOk   = &pairOk;
endmodule

// File: rtl/uid_control.sv
module uid_control
  import nand_uid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       capOk,
  input  uidStatus_t sts,
  output uidStrobe_t stb,
  output logic       nandCmdLatch,
  output logic       nandAddrLatch,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] dqOut,
  output logic       dqOe,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [1:0] errCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_CMD_LO, S_CMD_HI, S_ADR_LO, S_ADR_HI,
    S_WAIT_WB, S_WAIT_RDY, S_WAIT_RR, S_RD_LO, S_RD_HI, S_CHECK
  } state_t;

  state_t  state, stateNext;
  logic    finishOk, finishErr;
  uidErr_t errSel;

  always_comb begin
    stateNext = state;
    stb       = '0;
    finishOk  = 1'b0;
    finishErr = 1'b0;
    errSel    = ERR_NONE;
    unique case (state)
      S_IDLE: if (start) begin
        if (!capOk) begin
          finishErr = 1'b1;
          errSel    = ERR_UNSUP;
        end else begin
          stateNext   = S_CMD_LO;
          stb.clrCopy = 1'b1;
          stb.clrByte = 1'b1;
        end
      end
      S_CMD_LO: stateNext = S_CMD_HI;
      S_CMD_HI: stateNext = S_ADR_LO;
      S_ADR_LO: stateNext = S_ADR_HI;
      S_ADR_HI: begin
        stateNext    = S_WAIT_WB;
        stb.clrTimer = 1'b1;
      end
      S_WAIT_WB: begin
        if (sts.wbHit) begin
          stateNext    = S_WAIT_RDY;
          stb.clrTimer = 1'b1;
        end else stb.incTimer = 1'b1;
      end
      S_WAIT_RDY: begin
        if (sts.rbReady) begin
          stateNext    = S_WAIT_RR;
          stb.clrTimer = 1'b1;
        end else if (sts.rHit) begin
          stateNext = S_IDLE;
          finishErr = 1'b1;
          errSel    = ERR_TIMEOUT;
        end else stb.incTimer = 1'b1;
      end
      S_WAIT_RR: begin
        if (sts.rrHit) stateNext = S_RD_LO;
        else           stb.incTimer = 1'b1;
      end
      S_RD_LO: begin
        stateNext   = S_RD_HI;
        stb.capByte = 1'b1;
      end
      S_RD_HI: stateNext = sts.copyFull ? S_CHECK : S_RD_LO;
      S_CHECK: begin
        if (sts.copyOk) begin
          stateNext   = S_IDLE;
          stb.latchId = 1'b1;
          finishOk    = 1'b1;
        end else if (sts.lastCopy) begin
          stateNext = S_IDLE;
          finishErr = 1'b1;
          errSel    = ERR_NOCOPY;
        end else begin
          stateNext   = S_RD_LO;
          stb.incCopy = 1'b1;
          stb.clrByte = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end else if (finishOk) begin
      done    <= 1'b1;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end else if (finishErr) begin
      done    <= 1'b1;
      error   <= 1'b1;
      errCode <= errSel;
    end else if (state == S_IDLE && start) begin
      done    <= 1'b0;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end
  end

  assign nandCmdLatch  = (state == S_CMD_LO) || (state == S_CMD_HI);
  assign nandAddrLatch = (state == S_ADR_LO) || (state == S_ADR_HI);
  assign nandWeN       = !((state == S_CMD_LO) || (state == S_ADR_LO));
  assign nandReN       = (state != S_RD_LO);
  assign dqOe          = nandCmdLatch || nandAddrLatch;
  assign dqOut         = nandCmdLatch ? UID_OPCODE : UID_ADDRESS;
  assign busy          = (state != S_IDLE);
endmodule

// File: rtl/nand_uid_reader.sv
module nand_uid_reader
  import nand_uid_pkg::*;
#(
  parameter int ID_BYTES   = 16,
  parameter int MAX_COPIES = 16,
  parameter int TMR_W      = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [15:0]               optCmd,
  input  logic [7:0]                mfrId,
  input  logic [TMR_W-1:0]          tWbCycles,
  input  logic [TMR_W-1:0]          tRCycles,
  input  logic [TMR_W-1:0]          tRrCycles,
  input  logic                      nandRbN,
  input  logic [7:0]                dqIn,
  output logic                      nandCmdLatch,
  output logic                      nandAddrLatch,
  output logic                      nandWeN,
  output logic                      nandReN,
  output logic [7:0]                dqOut,
  output logic                      dqOe,
  output logic                      busy,
  output logic                      done,
  output logic                      error,
  output logic [1:0]                errCode,
  output logic [(ID_BYTES+1)*8-1:0] idOut
);
  localparam int OUT_W = (ID_BYTES + 1) * 8;

  uidStrobe_t stb;
  uidStatus_t sts;

  uid_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .capOk(optCmd[CAP_BIT]),
    .sts(sts), .stb(stb),
    .nandCmdLatch(nandCmdLatch), .nandAddrLatch(nandAddrLatch),
    .nandWeN(nandWeN), .nandReN(nandReN), .dqOut(dqOut), .dqOe(dqOe),
    .busy(busy), .done(done), .error(error), .errCode(errCode)
  );

  uid_datapath #(
    .ID_BYTES(ID_BYTES), .MAX_COPIES(MAX_COPIES), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tWbCycles(tWbCycles), .tRCycles(tRCycles), .tRrCycles(tRrCycles),
    .nandRbN(nandRbN), .dqIn(dqIn), .mfrId(mfrId),
    .sts(sts), .idOut(idOut)
  );
endmodule

// File: rtl/uid_reader_chk.sv
module uid_reader_chk #(
  parameter int OUT_W = 136
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             capBit,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [1:0]       errCode,
  input logic [OUT_W-1:0] idOut,
  input logic             cmdLatch,
  input logic             addrLatch,
  input logic             weN,
  input logic             reN,
  input logic             dqOe
);
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdLatch && addrLatch));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  // R3
  we_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> dqOe);

  // R2
  unsup_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !capBit) |=> (done && error && errCode == 2'd1));

  // R9
  id_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idOut) |-> (done && !error));

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind nand_uid_reader uid_reader_chk #(.OUT_W(OUT_W)) i_uid_chk (
  .clk(clk), .rstN(rstN), .start(start), .capBit(optCmd[5]),
  .busy(busy), .done(done), .error(error), .errCode(errCode), .idOut(idOut),
  .cmdLatch(nandCmdLatch), .addrLatch(nandAddrLatch),
  .weN(nandWeN), .reN(nandReN), .dqOe(dqOe)
);

// File: tb/test_nand_uid_reader.sv
module test_nand_uid_reader;
  localparam int CLK_PERIOD = 10;
  localparam int IDB = 16;
  localparam int NCOPY = 16;
  localparam int TW = 16;
  localparam int OW = (IDB + 1) * 8;

  logic clk = 0, rstN = 0, start = 0, nandRbN = 1;
  logic [15:0] optCmd = 16'h0020;
  logic [7:0] mfrId = 8'h2C, dqIn = 8'h00;
  logic [TW-1:0] tWbCycles = 4, tRCycles = 60, tRrCycles = 3;
  logic nandCmdLatch, nandAddrLatch, nandWeN, nandReN, dqOe, busy, done, error;
  logic [7:0] dqOut;
  logic [1:0] errCode;
  logic [OW-1:0] idOut;

  int total = 0, bad = 0, cyc = 0;
  int reads = 0, adrCycle = 0, rbHighCycle = 0, firstRe = -1;
  int rbMode = 0;
  logic [7:0] cmdQ[$], adrQ[$], dataQ[$];
  event adrEv;

  nand_uid_reader i_nand_uid_reader (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [OW-1:0] act, input logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // die model: bus capture
  always @(posedge nandWeN) begin
    #1;
    if (nandCmdLatch) cmdQ.push_back(dqOut);
    if (nandAddrLatch) begin
      adrQ.push_back(dqOut);
      adrCycle = cyc;
      ->adrEv;
    end
  end

  always @(negedge nandReN) begin
    if (firstRe < 0) firstRe = cyc;
    reads++;
    dqIn <= (dataQ.size() > 0) ? dataQ.pop_front() : 8'h5A;
  end

  // die model: ready/busy
  always begin
    @(adrEv);
    if (rbMode == 0) begin
      repeat (2) @(negedge clk);
      nandRbN = 0;
      repeat (20) @(negedge clk);
      nandRbN = 1;
      rbHighCycle = cyc;
    end else if (rbMode == 1) begin
      @(negedge clk);
      nandRbN = 0;
    end
  end

  // per-clock bus rules (R3, R10)
  always @(negedge clk) if (rstN) begin
    chk(!(nandCmdLatch && nandAddrLatch), "R3", "latch strobes together",
        OW'({nandCmdLatch, nandAddrLatch}), OW'(0));
    chk(!(done && busy), "R10", "done with busy", OW'({done, busy}), OW'(2));
    if (!busy)
      chk(nandWeN && nandReN, "R10", "strobes idle", OW'({nandWeN, nandReN}), OW'(3));
  end

  function automatic logic [7:0] idByte(int seed, int c, int j);
    return 8'(seed + c * 17 + j * 29 + 3);
  endfunction

  // Builds copies 0..ncopy-1; copy goodIdx passes, others carry one flipped bit
  task automatic fillCopies(int seed, int ncopy, int goodIdx);
    dataQ.delete();
    for (int c = 0; c < ncopy; c++) begin
      logic [7:0] cp [2*IDB];
      for (int j = 0; j < IDB; j++) begin
        cp[j] = idByte(seed, c, j);
        cp[j + IDB] = ~cp[j];
      end
      if (c != goodIdx) cp[IDB + (c * 5) % IDB] ^= 8'(1 << (c % 8));
      for (int j = 0; j < 2 * IDB; j++) dataQ.push_back(cp[j]);
    end
  endtask

  function automatic logic [OW-1:0] expId(int seed, int c);
    logic [OW-1:0] v;
    v[OW-1 -: 8] = mfrId;
    for (int j = 0; j < IDB; j++) v[(IDB-1-j)*8 +: 8] = idByte(seed, c, j);
    return v;
  endfunction

  task automatic runOp(input bit extraStart);
    cmdQ.delete(); adrQ.delete();
    reads = 0; firstRe = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (extraStart) begin
      repeat (8) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && errCode == 0, "R1", "status", OW'({busy, done, error, errCode}), OW'(0));
    chk(idOut == '0, "R1", "idOut", idOut, '0);
    chk(nandWeN && nandReN && !nandCmdLatch && !nandAddrLatch, "R1", "bus",
        OW'({nandWeN, nandReN, nandCmdLatch, nandAddrLatch}), OW'(4'b1100));
    rstN = 1;

    // R2 unsupported
    optCmd = 16'hFFDF;
    runOp(0);
    chk(error && errCode == 1, "R2", "unsupported code", OW'({error, errCode}), OW'(3'b101));
    repeat (4) @(negedge clk);
    chk(cmdQ.size() == 0 && reads == 0, "R2", "no bus cycles", OW'(cmdQ.size() + reads), OW'(0));
    chk(idOut == '0, "R9", "idOut untouched on refuse", idOut, '0);
    optCmd = 16'h0020;

    // first copy good, extra start while busy
    rbMode = 0; fillCopies(1, 1, 0);
    runOp(1);
    chk(cmdQ.size() == 1 && cmdQ[0] == 8'hED, "R3", "command byte", OW'(cmdQ.size() > 0 ? cmdQ[0] : 0), OW'(8'hED));
    chk(adrQ.size() == 1 && adrQ[0] == 8'h00, "R3", "address byte", OW'(adrQ.size()), OW'(1));
    chk(firstRe - rbHighCycle >= tRrCycles, "R4", "ready to read gap", OW'(firstRe - rbHighCycle), OW'(tRrCycles));
    chk(!error && errCode == 0, "R7", "copy0 status", OW'({error, errCode}), OW'(0));
    chk(reads == 32, "R7", "copy0 reads", OW'(reads), OW'(32));
    chk(idOut == expId(1, 0), "R9", "copy0 id", idOut, expId(1, 0));
    repeat (5) @(negedge clk);
    chk(done && !busy, "R10", "done held", OW'({done, busy}), OW'(2));

    // copy 5 first good; earlier copies single-bit bad (R6)
    rbMode = 0; fillCopies(7, 6, 5);
    runOp(0);
    chk(reads == 6 * 32, "R6", "bad copies rejected", OW'(reads), OW'(192));
    chk(idOut == expId(7, 5), "R9", "copy5 id", idOut, expId(7, 5));

    // last copy good
    fillCopies(11, 16, 15);
    runOp(0);
    chk(!error && reads == 512, "R7", "last copy pass", OW'(reads), OW'(512));
    chk(idOut == expId(11, 15), "R9", "copy15 id", idOut, expId(11, 15));

    // no valid copy
    held = idOut;
    fillCopies(19, 16, -1);
    runOp(0);
    chk(error && errCode == 3, "R8", "nocopy code", OW'({error, errCode}), OW'(3'b111));
    chk(reads == 512, "R8", "nocopy reads", OW'(reads), OW'(512));
    chk(idOut == held, "R9", "idOut kept on fail", idOut, held);

    // die never signals busy: tWb + tRr spacing
    rbMode = 2; fillCopies(23, 1, 0);
    runOp(0);
    chk(firstRe - adrCycle >= tWbCycles + tRrCycles, "R4", "wb plus rr delay",
        OW'(firstRe - adrCycle), OW'(tWbCycles + tRrCycles));
    chk(idOut == expId(23, 0), "R6", "pass after fast ready", idOut, expId(23, 0));

    // timeout
    held = idOut;
    rbMode = 1; fillCopies(29, 1, 0);
    runOp(0);
    chk(error && errCode == 2, "R5", "timeout code", OW'({error, errCode}), OW'(3'b110));
    chk(reads == 0, "R5", "no reads on timeout", OW'(reads), OW'(0));
    chk(idOut == held, "R9", "idOut kept on timeout", idOut, held);
    nandRbN = 1;

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule